// File: doc/BRIEF.md
# Comparator-Triggered Discharge Pulse Generator

This block times the capacitor-reset pulse of a sawtooth oscillator. A digital copy of a threshold comparator's output arrives on one pin and a bidirectional sync pin is split into separate input, output and enable signals. When the comparator level crosses in the chosen direction, the block drives its discharge output for a fixed number of clock cycles. In sync-input mode, an edge on the sync pin starts the same pulse. Between pulses the discharge output floats, so the capacitor can charge undisturbed.

In sync-output mode the sync pin echoes every discharge, so other oscillators can lock to this one. A long discharge runs out of reset. A long discharge also runs whenever the oscillator has produced no trigger for a full watchdog interval, which recovers a core that has stalled with its capacitor stuck at a rail. All durations are parameters given in clock cycles. Both asynchronous inputs pass through two-flop synchronizers.

Top module: `reset_pulse_gen`

## Requirements
- R1: A qualifying input change sampled on rising edge k raises `dis_oe_o` after rising edge k+2. `dis_oe_o` then stays high for exactly PULSE_CYC clock cycles.
- R2: While `dis_oe_o` is 0, `dis_lvl_o` is 0. While `dis_oe_o` is 1, `dis_lvl_o` equals DRIVE_HIGH (1 = drive the high rail, 0 = drive the low rail).
- R3: With CMP_INV=0 only a rising edge of `cmp_i` is a trigger. With CMP_INV=1 only a falling edge is a trigger.
- R4: With SYNC_IN_MODE=0, `sync_oe_o` is 1 and `sync_i` has no effect. `sync_o` equals SYNC_ACT_HIGH whenever `dis_oe_o` is 1, and equals its inverse otherwise. This includes the long discharges.
- R5: With SYNC_IN_MODE=1, `sync_oe_o` is 0 and `sync_o` holds the inactive level (the inverse of SYNC_ACT_HIGH). An edge on `sync_i` triggers a pulse with the same latency as R1. The edge is rising when SYNC_ACT_HIGH=1 and falling when SYNC_ACT_HIGH=0; the opposite edge has no effect.
- R6: `dis_oe_o` is 1 during reset. After release, `dis_oe_o` falls on the LONG_CYC-th rising edge. Triggers that arrive during this time have no effect.
- R7: After WDOG_CYC consecutive idle cycles with no trigger, `dis_oe_o` goes high for LONG_CYC cycles. The idle count restarts after every discharge.
- R8: A trigger that arrives while any discharge is active is discarded. It does not extend the pulse and does not start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator level, asynchronous |
| sync_i | input | 1 | Sync pin input value, asynchronous |
| sync_o | output | 1 | Sync pin output value |
| sync_oe_o | output | 1 | Sync pin output enable |
| dis_oe_o | output | 1 | Discharge driver enable (0 = high impedance) |
| dis_lvl_o | output | 1 | Discharge driven level |

## Verification
An input change driven before rising edge k shows on the discharge and sync outputs after rising edge k+2. The delay comes from two synchronizer flops and the state register. A pulse ends PULSE_CYC edges after it starts, and a long discharge ends LONG_CYC edges after it starts. The behavioural model in the bench applies that same edge arithmetic on every rising edge, and every output is compared on the following falling edge. Directed windows count high cycles after each stimulus to confirm pulse lengths, discarded triggers, the wrong-edge cases and the watchdog interval.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHORT = 2'd1,
    ST_LONG  = 2'd2
  } rpg_state_e;
endpackage

// File: rtl/rpg_edge_det.sv
module rpg_edge_det #(
  parameter bit INV = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= lvl_i ^ INV;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = s2_q & ~s3_q;
endmodule

// File: rtl/rpg_wdog.sv
module rpg_wdog #(
  parameter int unsigned WDOG_CYC = 48000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  output logic fire_o
);
  localparam int unsigned WW = $clog2(WDOG_CYC + 1);
  localparam logic [WW-1:0] LAST = WW'(WDOG_CYC - 1);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!idle_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fire_o = idle_i && (cnt_q == LAST);
endmodule

// File: rtl/rpg_seq.sv
module rpg_seq
  import rpg_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 60,
  parameter int unsigned LONG_CYC  = 300000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic wd_i,
  output logic busy_o
);
  localparam int unsigned MAXC = (LONG_CYC > PULSE_CYC) ? LONG_CYC : PULSE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  rpg_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LONG;
      cnt_q   <= CW'(LONG_CYC - 1);
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (trig_i) begin
            state_q <= ST_SHORT;
            cnt_q   <= CW'(PULSE_CYC - 1);
          end else if (wd_i) begin
            state_q <= ST_LONG;
            cnt_q   <= CW'(LONG_CYC - 1);
          end
        end
        ST_SHORT, ST_LONG: begin
          // triggers are dropped here
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/reset_pulse_gen.sv
module reset_pulse_gen #(
  parameter int unsigned PULSE_CYC     = 60,
  parameter int unsigned LONG_CYC      = 300000,
  parameter int unsigned WDOG_CYC      = 48000000,
  parameter bit          CMP_INV       = 1'b0,
  parameter bit          SYNC_IN_MODE  = 1'b0,
  parameter bit          SYNC_ACT_HIGH = 1'b0,
  parameter bit          DRIVE_HIGH    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  input  logic sync_i,
  output logic sync_o,
  output logic sync_oe_o,
  output logic dis_oe_o,
  output logic dis_lvl_o
);
  logic cmp_edge, sync_edge, trig, wd_fire, busy;

  rpg_edge_det #(.INV(CMP_INV)) u_cmp_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(cmp_i), .edge_o(cmp_edge)
  );

  rpg_edge_det #(.INV(~SYNC_ACT_HIGH)) u_sync_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(sync_i), .edge_o(sync_edge)
  );

  assign trig = cmp_edge | (sync_edge & SYNC_IN_MODE);

  rpg_wdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
    .clk_i (clk_i), .rst_ni(rst_ni), .idle_i(~busy), .fire_o(wd_fire)
  );

  rpg_seq #(.PULSE_CYC(PULSE_CYC), .LONG_CYC(LONG_CYC)) u_seq (
    .clk_i (clk_i), .rst_ni(rst_ni), .trig_i(trig), .wd_i(wd_fire), .busy_o(busy)
  );

  assign dis_oe_o  = busy;
  assign dis_lvl_o = busy & DRIVE_HIGH;
  assign sync_oe_o = ~SYNC_IN_MODE;
  assign sync_o    = (busy && !SYNC_IN_MODE) ? SYNC_ACT_HIGH : ~SYNC_ACT_HIGH;
endmodule

// File: rtl/reset_pulse_gen_chk.sv
module reset_pulse_gen_chk #(
  parameter int unsigned PULSE_CYC     = 60,
  parameter int unsigned LONG_CYC      = 300000,
  parameter int unsigned WDOG_CYC      = 48000000,
  parameter bit          SYNC_IN_MODE  = 1'b0,
  parameter bit          SYNC_ACT_HIGH = 1'b0,
  parameter bit          DRIVE_HIGH    = 1'b1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_o,
  input logic sync_oe_o,
  input logic dis_oe_o,
  input logic dis_lvl_o
);
  int unsigned hi_run, lo_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run <= 0;
      lo_run <= 0;
    end else begin
      hi_run <= dis_oe_o ? hi_run + 1 : 0;
      lo_run <= dis_oe_o ? 0 : lo_run + 1;
    end
  end

  a_r2_idle_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dis_oe_o |-> !dis_lvl_o);
  a_r2_rail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_oe_o |-> (dis_lvl_o == DRIVE_HIGH));
  a_r4_sync_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !SYNC_IN_MODE |-> (sync_oe_o && (sync_o == (dis_oe_o ? SYNC_ACT_HIGH : ~SYNC_ACT_HIGH))));
  a_r5_sync_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    SYNC_IN_MODE |-> (!sync_oe_o && sync_o == ~SYNC_ACT_HIGH));
  a_r1_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_run != 0 && !dis_oe_o) |-> (hi_run == PULSE_CYC || hi_run == LONG_CYC));
  a_r7_idle_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dis_oe_o |-> (lo_run < WDOG_CYC));
endmodule

bind reset_pulse_gen reset_pulse_gen_chk #(
  .PULSE_CYC(PULSE_CYC), .LONG_CYC(LONG_CYC), .WDOG_CYC(WDOG_CYC),
  .SYNC_IN_MODE(SYNC_IN_MODE), .SYNC_ACT_HIGH(SYNC_ACT_HIGH), .DRIVE_HIGH(DRIVE_HIGH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_o(sync_o), .sync_oe_o(sync_oe_o),
  .dis_oe_o(dis_oe_o), .dis_lvl_o(dis_lvl_o)
);

// File: tb/reset_pulse_gen_test.sv
`timescale 1ns/1ps
module reset_pulse_gen_test;
  localparam int P = 6;
  localparam int L = 40;
  localparam int W = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp = 1'b0;
  logic sync_in = 1'b0;
  logic so0, soe0, doe0, dlv0;
  logic so1, soe1, doe1, dlv1;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  // instance 0: rising comparator, sync output active low, high rail
  reset_pulse_gen #(.PULSE_CYC(P), .LONG_CYC(L), .WDOG_CYC(W), .CMP_INV(1'b0),
    .SYNC_IN_MODE(1'b0), .SYNC_ACT_HIGH(1'b0), .DRIVE_HIGH(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .sync_i(sync_in),
    .sync_o(so0), .sync_oe_o(soe0), .dis_oe_o(doe0), .dis_lvl_o(dlv0));

  // instance 1: falling comparator, sync input on rising edge, low rail
  reset_pulse_gen #(.PULSE_CYC(P), .LONG_CYC(L), .WDOG_CYC(W), .CMP_INV(1'b1),
    .SYNC_IN_MODE(1'b1), .SYNC_ACT_HIGH(1'b1), .DRIVE_HIGH(1'b0)) uut_in (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .sync_i(sync_in),
    .sync_o(so1), .sync_oe_o(soe1), .dis_oe_o(doe1), .dis_lvl_o(dlv1));

  // reference model
  int rem [2];
  int idle [2];
  bit ha [2][3];
  bit hs [3];

  task automatic step(input int i, input bit trig);
    if (rem[i] > 0) begin
      rem[i]--;
      idle[i] = 0;
    end else if (trig) begin
      rem[i] = P;
    end else if (idle[i] == W - 1) begin
      rem[i] = L;
    end else begin
      idle[i]++;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        rem[i] = L; idle[i] = 0;
        for (int j = 0; j < 3; j++) ha[i][j] = 1'b0;
      end
      for (int j = 0; j < 3; j++) hs[j] = 1'b0;
    end else begin
      step(0, ha[0][1] & ~ha[0][2]);
      step(1, (ha[1][1] & ~ha[1][2]) | (hs[1] & ~hs[2]));
      ha[0][2] = ha[0][1]; ha[0][1] = ha[0][0]; ha[0][0] = cmp;
      ha[1][2] = ha[1][1]; ha[1][1] = ha[1][0]; ha[1][0] = ~cmp;
      hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = sync_in;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R1 dis_oe inst0", doe0, rem[0] > 0);
    chk("R1 dis_oe inst1", doe1, rem[1] > 0);
    chk("R2 dis_lvl inst0", dlv0, rem[0] > 0);
    chk("R2 dis_lvl inst1", dlv1, 0);
    chk("R4 sync_o inst0", so0, !(rem[0] > 0));
    chk("R4 sync_oe inst0", soe0, 1);
    chk("R5 sync_o inst1", so1, 0);
    chk("R5 sync_oe inst1", soe1, 0);
  end

  task automatic win(input int n, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      c0 += doe0; c1 += doe1;
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0, c1;
    repeat (4) @(negedge clk);
    chk("R6 reset busy inst0", doe0, 1);
    chk("R6 reset busy inst1", doe1, 1);
    rst_n = 1'b1;
    // R6: edges during power-up discharge ignored
    fork
      win(L + 5, c0, c1);
      begin
        repeat (2) @(negedge clk); cmp = 1'b1;
        repeat (8) @(negedge clk); cmp = 1'b0;
      end
    join
    chk("R6 long len inst0", c0, L - 1);
    chk("R6 long len inst1", c1, L - 1);
    // R1/R3 rising edge
    cmp = 1'b1;
    win(3 * P, c0, c1);
    chk("R1 pulse len rise", c0, P);
    chk("R3 inst1 ignores rise", c1, 0);
    // R3 falling edge
    cmp = 1'b0;
    win(3 * P, c0, c1);
    chk("R3 inst1 fall pulse", c1, P);
    chk("R3 inst0 ignores fall", c0, 0);
    // R8 retrigger during pulse discarded
    cmp = 1'b1;
    fork
      win(4 * P, c0, c1);
      begin
        repeat (3) @(negedge clk); cmp = 1'b0;
        repeat (1) @(negedge clk); cmp = 1'b1;
      end
    join
    chk("R8 no retrigger inst0", c0, P);
    cmp = 1'b0;
    win(3 * P, c0, c1);
    chk("R3 inst1 fall after R8", c1, P);
    // R5 sync input / R4 ignored
    sync_in = 1'b1;
    win(3 * P, c0, c1);
    chk("R5 sync rise pulse", c1, P);
    chk("R4 sync_i ignored inst0", c0, 0);
    sync_in = 1'b0;
    win(3 * P, c0, c1);
    chk("R5 sync fall ignored", c1, 0);
    chk("R4 sync_i fall ignored", c0, 0);
    // R7 watchdog
    win(W + L + 20, c0, c1);
    chk("R7 wdog long inst0", c0, L);
    chk("R7 wdog long inst1", c1, L);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule